// File: doc/BRIEF.md
# Phase-Aligned Integer Clock Divider Bank

This block holds a bank of integer clock dividers that share one input clock. Each divider has its own high-count and low-count fields, so both the output period and the duty cycle can be programmed. Ratios from 2 to 32 come from these counts. Divide-by-1 is a bypass that sends the input clock straight to the output.

Each divider also has a starting-phase value. This value delays its first rising edge after a restart by a whole number of input cycles, which sets a coarse skew between outputs. A shared restart lines all dividers up together. The restart can come from an active-low pin or from a one-cycle software request. It also commits the configuration that the dividers run with, so a field written between restarts never reaches a running output.

The outputs are clocks built from registered state. Only the bypass path is a direct mux from the input clock. Each request source passes through two register stages before it reaches the dividers.

Top module: `clkdiv_bank`

## Requirements
- R1: With high count H and low count L (4 bits each), a divider not in bypass repeats with a period of H+L+2 input cycles and stays high for H+1 of them, so every ratio from 2 to 32 is reachable.
- R2: With bypass set, the output follows the input clock (divide by 1) from the first input edge after restart onward, and the phase value has no effect.
- R3: With phase value P (4 bits), a divider's output first rises on the input edge P cycles after the first edge at which the restart is no longer applied, so two dividers with different P keep that difference as their skew.
- R4: The restart pin is active low. A level sampled low at input edge k applies the restart at edges k+2 onward, and while the restart is applied every output reads low.
- R5: A software request held high for one input edge k applies the restart at edge k+2 only, with the same effect as the pin.
- R6: Count, phase and bypass fields are captured only at edges where the restart is applied; changes made at other times leave the outputs unchanged until the next restart.
- R7: During reset all outputs read low. After reset is released, every divider runs at ratio 2 with phase 0 and no bypass until the first restart.
- R8: When both request sources are active, the restart stays applied while either one is, and counting starts from the later release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Restart pin, active low |
| soft_sync_i | input | 1 | One-cycle software restart request |
| hi_cnt_i | input | NUM_DIV*4 | High count per divider, divider i at bits [4i+3:4i] |
| lo_cnt_i | input | NUM_DIV*4 | Low count per divider, same packing |
| phase_i | input | NUM_DIV*4 | Starting phase per divider, same packing |
| bypass_i | input | NUM_DIV | Divide-by-1 bypass per divider |
| div_o | output | NUM_DIV | Divided clock outputs |

## Verification
The pin restart and the software restart can be active in the same cycle. The bench tests this by pulsing the software request on the same edge that releases the pin. The expected start is the one the software request gives, one cycle after the pin alone would start counting. A software pulse sent while the pin is held low must leave the start unchanged. A configuration write can also land in a cycle when no restart is applied. The bench changes all fields in the middle of a run and checks that the outputs keep following the period, duty and skew of the old configuration until a later restart.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W = 4;
  localparam int PH_W  = 4;
  localparam int CW    = (CNT_W > PH_W) ? CNT_W : PH_W;

  typedef struct packed {
    logic             byp;
    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } div_cfg_t;

  localparam int CFG_W = $bits(div_cfg_t);
endpackage

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  input  logic soft_sync_i,
  output logic sync_req_o
);
  logic [STAGES-1:0] pin_sr;
  logic [STAGES-1:0] soft_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_sr  <= '1;
      soft_sr <= '0;
    end else begin
      pin_sr  <= {pin_sr[STAGES-2:0], sync_ni};
      soft_sr <= {soft_sr[STAGES-2:0], soft_sync_i};
    end
  end

  assign sync_req_o = ~pin_sr[STAGES-1] | soft_sr[STAGES-1];
endmodule

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  div_cfg_t [NUM_DIV-1:0]  cfg_i,
  output div_cfg_t [NUM_DIV-1:0]  cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (load_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sync_req_i,
  input  div_cfg_t cfg_live_i,
  input  div_cfg_t cfg_run_i,
  output logic     div_q_o,
  output logic     div_o
);
  logic [CW-1:0] cnt_q;
  logic          out_q;
  logic          hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (sync_req_i) begin
      out_q  <= 1'b0;
      cnt_q  <= CW'(cfg_live_i.ph);
      hold_q <= 1'b1;
    end else begin
      hold_q <= 1'b0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        out_q <= ~out_q;
        // going high loads the high count, going low the low count
        cnt_q <= out_q ? CW'(cfg_run_i.lo) : CW'(cfg_run_i.hi);
      end
    end
  end

  assign div_q_o = out_q;
  assign div_o   = (cfg_run_i.byp && !hold_q) ? clk_i : out_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_ni,
  input  logic                     soft_sync_i,
  input  logic [NUM_DIV*CNT_W-1:0] hi_cnt_i,
  input  logic [NUM_DIV*CNT_W-1:0] lo_cnt_i,
  input  logic [NUM_DIV*PH_W-1:0]  phase_i,
  input  logic [NUM_DIV-1:0]       bypass_i,
  output logic [NUM_DIV-1:0]       div_o
);
  logic                   sync_req;
  div_cfg_t [NUM_DIV-1:0] cfg_live;
  div_cfg_t [NUM_DIV-1:0] shadow;
  logic [NUM_DIV-1:0]     div_q;

  clkdiv_sync_ctrl #(.STAGES(2)) i_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_ni     (sync_ni),
    .soft_sync_i (soft_sync_i),
    .sync_req_o  (sync_req)
  );

  clkdiv_shadow #(.NUM_DIV(NUM_DIV)) i_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sync_req),
    .cfg_i  (cfg_live),
    .cfg_o  (shadow)
  );

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    assign cfg_live[i].byp = bypass_i[i];
    assign cfg_live[i].ph  = phase_i[i*PH_W +: PH_W];
    assign cfg_live[i].hi  = hi_cnt_i[i*CNT_W +: CNT_W];
    assign cfg_live[i].lo  = lo_cnt_i[i*CNT_W +: CNT_W];

    clkdiv_core i_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_req_i (sync_req),
      .cfg_live_i (cfg_live[i]),
      .cfg_run_i  (shadow[i]),
      .div_q_o    (div_q[i]),
      .div_o      (div_o[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sync_ni,
  input logic                       soft_sync_i,
  input logic                       sync_req,
  input logic [NUM_DIV-1:0]         div_q,
  input logic [NUM_DIV*CFG_W-1:0]   cfg_live,
  input logic [NUM_DIV*CFG_W-1:0]   shadow
);
  p_hold_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req |=> (div_q == '0));

  p_pin_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ni |-> ##2 sync_req);

  p_soft_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_sync_i |-> ##2 sync_req);

  p_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_req) |-> (div_q == '0));

  p_shadow_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_req |=> $stable(shadow));

  p_shadow_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req |=> (shadow == $past(cfg_live)));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_DIV(NUM_DIV)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_ni     (sync_ni),
  .soft_sync_i (soft_sync_i),
  .sync_req    (sync_req),
  .div_q       (div_q),
  .cfg_live    (cfg_live),
  .shadow      (shadow)
);

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {byp0, byp1, hi0, lo0, ph0, hi1, lo1, ph1}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0,  4'd0,  4'd0,  4'd0,  4'd0,  4'd3},
    {1'b0, 1'b0, 4'd1,  4'd2,  4'd5,  4'd2,  4'd1,  4'd0},
    {1'b0, 1'b0, 4'd7,  4'd7,  4'd15, 4'd3,  4'd12, 4'd1},
    {1'b0, 1'b0, 4'd15, 4'd0,  4'd2,  4'd0,  4'd15, 4'd9},
    {1'b1, 1'b0, 4'd4,  4'd4,  4'd7,  4'd4,  4'd4,  4'd7},
    {1'b0, 1'b1, 4'd9,  4'd6,  4'd11, 4'd1,  4'd1,  4'd14},
    {1'b1, 1'b1, 4'd0,  4'd0,  4'd15, 4'd0,  4'd0,  4'd0},
    {1'b0, 1'b0, 4'd15, 4'd15, 4'd15, 4'd15, 4'd15, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_ni = 1'b1;
  logic soft_sync = 1'b0;
  logic [3:0] hi_d [2];
  logic [3:0] lo_d [2];
  logic [3:0] ph_d [2];
  logic [1:0] byp_d;
  logic [1:0] div_o;

  int hi_r [2];
  int lo_r [2];
  int ph_r [2];
  bit byp_r [2];
  int m_idx;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_bank #(.NUM_DIV(2)) i_clkdiv_bank (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sync_ni     (sync_ni),
    .soft_sync_i (soft_sync),
    .hi_cnt_i    ({hi_d[1], hi_d[0]}),
    .lo_cnt_i    ({lo_d[1], lo_d[0]}),
    .phase_i     ({ph_d[1], ph_d[0]}),
    .bypass_i    (byp_d),
    .div_o       (div_o)
  );

  function automatic logic exp_out(int m, int hi, int lo, int ph);
    int t = m - ph;
    if (t < 0) return 1'b0;
    return ((t % (hi + lo + 2)) < (hi + 1));
  endfunction

  task automatic drive(bit b0, bit b1, int h0, int l0, int p0, int h1, int l1, int p1);
    byp_d = {b1, b0};
    hi_d[0] = 4'(h0); lo_d[0] = 4'(l0); ph_d[0] = 4'(p0);
    hi_d[1] = 4'(h1); lo_d[1] = 4'(l1); ph_d[1] = 4'(p1);
  endtask

  task automatic commit_ref();
    for (int i = 0; i < 2; i++) begin
      hi_r[i] = int'(hi_d[i]); lo_r[i] = int'(lo_d[i]);
      ph_r[i] = int'(ph_d[i]); byp_r[i] = byp_d[i];
    end
  endtask

  task automatic check(string req, bit ok, int act, int expv, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // caller sits at a negedge; first step samples after the restart-free edge
  task automatic check_run(int n, string req);
    int bad [2] = '{0, 0};
    int act [2] = '{0, 0};
    int ex  [2] = '{0, 0};
    int at  [2] = '{0, 0};
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      for (int i = 0; i < 2; i++) begin
        logic e = byp_r[i] ? 1'b1 : exp_out(m_idx, hi_r[i], lo_r[i], ph_r[i]);
        if (div_o[i] !== e && bad[i] == 0) begin
          bad[i] = 1; act[i] = int'(div_o[i]); ex[i] = int'(e); at[i] = m_idx;
        end
      end
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        logic e = byp_r[i] ? 1'b0 : exp_out(m_idx, hi_r[i], lo_r[i], ph_r[i]);
        if (div_o[i] !== e && bad[i] == 0) begin
          bad[i] = 1; act[i] = int'(div_o[i]); ex[i] = int'(e); at[i] = m_idx;
        end
      end
      m_idx++;
    end
    for (int i = 0; i < 2; i++)
      check(req, bad[i] == 0, act[i], ex[i],
            $sformatf("divider %0d waveform at cycle %0d", i, at[i]));
  endtask

  task automatic hold_check(string req);
    @(posedge clk); #(CLK_PERIOD/4);
    check(req, div_o == 2'b00, int'(div_o), 0, "outputs during restart");
    @(negedge clk);
  endtask

  task automatic pin_sync();
    sync_ni = 1'b0;
    repeat (2) @(posedge clk);
    hold_check("R4");
    commit_ref();
    sync_ni = 1'b1;
    repeat (2) @(negedge clk);
    m_idx = 0;
  endtask

  task automatic soft_pulse_sync();
    soft_sync = 1'b1;
    @(negedge clk);
    soft_sync = 1'b0;
    commit_ref();
    repeat (2) @(negedge clk);
    m_idx = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    @(posedge clk); #(CLK_PERIOD/4);
    check("R7", div_o == 2'b00, int'(div_o), 0, "outputs in reset");
    @(negedge clk);
    // R7: free run at ratio 2 after reset, fields still zero
    drive(0, 0, 5, 5, 9, 3, 3, 3);
    commit_ref();
    for (int i = 0; i < 2; i++) begin hi_r[i] = 0; lo_r[i] = 0; ph_r[i] = 0; byp_r[i] = 0; end
    rst_ni = 1'b1;
    m_idx = 0;
    check_run(12, "R7");

    // R1 R2 R3 R4: table of vectors via pin restart
    for (int v = 0; v < NV; v++) begin
      logic [25:0] w = VEC[v];
      drive(w[25], w[24], int'(w[23:20]), int'(w[19:16]), int'(w[15:12]),
            int'(w[11:8]), int'(w[7:4]), int'(w[3:0]));
      pin_sync();
      check_run(80, (w[25] | w[24]) ? "R2" : "R1");
    end

    // R1 R3: every ratio 2..32 with skew between the two dividers
    for (int r = 2; r <= 32; r++) begin
      int h = (r - 2) / 2;
      int l = r - 2 - h;
      drive(0, 0, h, l, r % 16, l, h, (r * 3) % 16);
      pin_sync();
      check_run(80, "R3");
    end

    // R5: software request alone
    drive(0, 0, 2, 4, 6, 5, 0, 1);
    soft_pulse_sync();
    check_run(50, "R5");

    // R6: change every field mid-run without restart; old settings persist
    drive(1, 0, 9, 1, 0, 0, 9, 12);
    check_run(60, "R6");
    // R6: next restart picks up the new fields
    pin_sync();
    check_run(40, "R6");

    // R8: soft pulse while pin held low has no extra effect
    drive(0, 0, 3, 3, 2, 1, 6, 8);
    sync_ni = 1'b0;
    repeat (2) @(negedge clk);
    soft_sync = 1'b1;
    @(negedge clk);
    soft_sync = 1'b0;
    repeat (3) @(negedge clk);
    hold_check("R8");
    commit_ref();
    sync_ni = 1'b1;
    repeat (2) @(negedge clk);
    m_idx = 0;
    check_run(40, "R8");

    // R8: soft pulse on the pin release edge, later release governs
    drive(0, 0, 0, 1, 4, 2, 2, 0);
    sync_ni = 1'b0;
    repeat (4) @(negedge clk);
    sync_ni = 1'b1;
    soft_pulse_sync();
    check_run(40, "R8");

    // R3: largest phase against zero phase at the longest ratio
    drive(0, 0, 15, 15, 15, 15, 15, 0);
    soft_pulse_sync();
    check_run(80, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule